// File: doc/BRIEF.md
# In-System Programming Data Register Bank

This block holds the test data registers that a JTAG TAP controller reaches while a device is programmed in-system. The TAP controller supplies the usual data-register strobes (capture, shift, update and a clock-DR enable), the serial input TDI and a one-hot select that names the active register. The bank returns TDO and three results to the rest of the chip: a device-reset request, a programming-enabled flag and a command word with its go pulse.

There are three registers. A one-bit reset register drives the device-reset request straight from its flop, with no update stage. A 16-bit unlock register raises the programming-enabled flag only while it holds the exact key 0xA370. A 15-bit command register takes a new programming command serially while the result of the previous command, loaded at capture, leaves on TDO. Every register shifts toward bit 0 and takes TDI into its top bit, so data enters and leaves least significant bit first.

Top module: `isp_dr_bank`

## Requirements
- R1: While rst_n is low and on the first cycle after it, dev_rst, prog_en, cmd_word, cmd_go and tdo (with sel = 0) are all 0.
- R2: Select bit 0 picks the reset register; a clock edge with clock_dr, shift_dr and sel[0] high loads tdi into it, and dev_rst shows the new value straight after that edge, stays at 1 while the register holds 1 and drops when a 0 is shifted in.
- R3: update_dr has no effect on dev_rst; dev_rst changes only on an edge that shifts the reset register.
- R4: Select bit 1 picks the 16-bit unlock register, shifted LSB first from tdi; prog_en is 1 exactly while its contents equal 0xA370.
- R5: Any other contents of the unlock register, such as 0xA371, keep prog_en at 0.
- R6: prog_clr high at a clock edge clears the unlock register to zero, taking priority over a shift in the same cycle.
- R7: Select bit 2 picks the 15-bit command register; an edge with clock_dr, capture_dr and sel[2] high loads result_in into it, and capture takes priority over a shift in the same cycle.
- R8: The command register shifts LSB first from tdi, cmd_word shows its contents, and tdo carries bit 0 of the selected register, so a captured result leaves least significant bit first while the new command enters.
- R9: cmd_go is 1 while update_dr and sel[2] are high and prog_en is 1, and 0 otherwise.
- R10: tdo is 0 whenever no select bit is set.
- R11: No register changes on an edge unless clock_dr and its own select bit are both high; strobes aimed at another register or given without clock_dr leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Power-on reset, active low |
| sel | input | 3 | One-hot register select: bit 0 reset, bit 1 unlock, bit 2 command |
| capture_dr | input | 1 | Capture strobe from the TAP controller |
| shift_dr | input | 1 | Shift strobe from the TAP controller |
| update_dr | input | 1 | Update strobe from the TAP controller |
| clock_dr | input | 1 | Data-register clock enable |
| tdi | input | 1 | Serial data in |
| prog_clr | input | 1 | Clears the unlock register when programming mode is left |
| result_in | input | CMD_W | Result of the previous command, loaded at capture |
| tdo | output | 1 | Serial data out, bit 0 of the selected register |
| dev_rst | output | 1 | Device-reset request |
| prog_en | output | 1 | Programming enabled |
| cmd_word | output | CMD_W | Current command register contents |
| cmd_go | output | 1 | Command issue pulse at update |

## Verification
On every cycle the checker confirms that the reset request follows a shift into the reset register and holds otherwise whatever update does, that a clear drops the enable flag, that capture loads the result, that unselected or unclocked strobes leave the command and enable state alone, that TDO idles at 0, and that the go pulse never appears while locked. Only the directed scenarios show the bit order of a full 16-bit and 15-bit transfer, that the exact key unlocks while a one-bit-off value does not, that a captured result comes back on TDO least significant bit first, and that a clear really zeroes the stored unlock value as seen by shifting it out.

// File: rtl/isp_dr_pkg.sv
package isp_dr_pkg;
   localparam int unsigned NREG     = 3;
   localparam int unsigned IDX_RST  = 0;
   localparam int unsigned IDX_KEY  = 1;
   localparam int unsigned IDX_CMD  = 2;

   typedef struct packed {
      logic capture;
      logic shift;
      logic update;
      logic clk_en;
   } dr_strobe_t;
endpackage

// File: rtl/isp_shift_reg.sv
module isp_shift_reg #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         capture,
   input  logic         shift,
   input  logic         clear,
   input  logic         din,
   input  logic [W-1:0] pin,
   output logic [W-1:0] q
);
   generate
      if (W < 1) begin : g_bad_width
         $error("isp_shift_reg: W must be at least 1");
      end

      if (W == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              q <= '0;
            else if (clear)          q <= '0;
            else if (en && capture)  q <= pin;
            else if (en && shift)    q <= din;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              q <= '0;
            else if (clear)          q <= '0;
            else if (en && capture)  q <= pin;
            else if (en && shift)    q <= {din, q[W-1:1]};
         end
      end
   endgenerate
endmodule

// File: rtl/isp_key_match.sv
module isp_key_match #(
   parameter int unsigned  W   = 16,
   parameter logic [W-1:0] KEY = '0
) (
   input  logic [W-1:0] value,
   output logic         match
);
   generate
      if (W < 2) begin : g_bad_width
         $error("isp_key_match: key width must be at least 2");
      end
   endgenerate

   always_comb match = (value == KEY);
endmodule

// File: rtl/isp_tdo_mux.sv
module isp_tdo_mux #(
   parameter int unsigned N = 3
) (
   input  logic [N-1:0] sel,
   input  logic [N-1:0] lsb,
   output logic         tdo
);
   logic [N-1:0] term;

   generate
      if (N < 1) begin : g_bad_count
         $error("isp_tdo_mux: need at least one register");
      end
      for (genvar i = 0; i < N; i++) begin : g_term
         assign term[i] = sel[i] & lsb[i];
      end
   endgenerate

   assign tdo = |term;
endmodule

// File: rtl/isp_dr_bank.sv
module isp_dr_bank
   import isp_dr_pkg::*;
#(
   parameter int unsigned        KEY_W = 16,
   parameter logic [KEY_W-1:0]   KEY   = 16'hA370,
   parameter int unsigned        CMD_W = 15
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NREG-1:0]      sel,
   input  logic                 capture_dr,
   input  logic                 shift_dr,
   input  logic                 update_dr,
   input  logic                 clock_dr,
   input  logic                 tdi,
   input  logic                 prog_clr,
   input  logic [CMD_W-1:0]     result_in,
   output logic                 tdo,
   output logic                 dev_rst,
   output logic                 prog_en,
   output logic [CMD_W-1:0]     cmd_word,
   output logic                 cmd_go
);
   localparam int unsigned RST_W = 1;

   generate
      if (CMD_W < 1) begin : g_bad_cmd
         $error("isp_dr_bank: CMD_W must be at least 1");
      end
   endgenerate

   dr_strobe_t      stb;
   logic [NREG-1:0] reg_en;
   logic [NREG-1:0] lsb;
   logic [RST_W-1:0] rst_q;
   logic [KEY_W-1:0] key_q;

   always_comb begin
      stb.capture = capture_dr;
      stb.shift   = shift_dr;
      stb.update  = update_dr;
      stb.clk_en  = clock_dr;
   end

   // Each register is clocked by clock-DR qualified with its own select bit.
   generate
      for (genvar i = 0; i < NREG; i++) begin : g_en
         assign reg_en[i] = stb.clk_en & sel[i];
      end
   endgenerate

   // Reset register: no capture, no update stage; output taken from the flop.
   isp_shift_reg #(.W(RST_W)) u_rst_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (reg_en[IDX_RST]),
      .capture (1'b0),
      .shift   (stb.shift),
      .clear   (1'b0),
      .din     (tdi),
      .pin     ('0),
      .q       (rst_q)
   );

   // Unlock register: cleared when programming mode is left.
   isp_shift_reg #(.W(KEY_W)) u_key_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (reg_en[IDX_KEY]),
      .capture (1'b0),
      .shift   (stb.shift),
      .clear   (prog_clr),
      .din     (tdi),
      .pin     ('0),
      .q       (key_q)
   );

   isp_key_match #(.W(KEY_W), .KEY(KEY)) u_key_cmp (
      .value (key_q),
      .match (prog_en)
   );

   // Command register: result in at capture, command in by shift.
   isp_shift_reg #(.W(CMD_W)) u_cmd_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (reg_en[IDX_CMD]),
      .capture (stb.capture),
      .shift   (stb.shift),
      .clear   (1'b0),
      .din     (tdi),
      .pin     (result_in),
      .q       (cmd_word)
   );

   assign lsb[IDX_RST] = rst_q[0];
   assign lsb[IDX_KEY] = key_q[0];
   assign lsb[IDX_CMD] = cmd_word[0];

   isp_tdo_mux #(.N(NREG)) u_tdo_mux (
      .sel (sel),
      .lsb (lsb),
      .tdo (tdo)
   );

   assign dev_rst = rst_q[0];
   assign cmd_go  = stb.update & sel[IDX_CMD] & prog_en;
endmodule

// File: rtl/isp_dr_bank_chk.sv
module isp_dr_bank_chk #(
   parameter int unsigned CMD_W = 15
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2:0]       sel,
   input logic             capture_dr,
   input logic             shift_dr,
   input logic             clock_dr,
   input logic             tdi,
   input logic             prog_clr,
   input logic [CMD_W-1:0] result_in,
   input logic             tdo,
   input logic             dev_rst,
   input logic             prog_en,
   input logic [CMD_W-1:0] cmd_word,
   input logic             cmd_go
);
   p_sel_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel));

   p_rst_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (clock_dr && shift_dr && sel[0]) |=> (dev_rst == $past(tdi)));

   p_rst_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(clock_dr && shift_dr && sel[0]) |=> $stable(dev_rst));

   p_key_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      prog_clr |=> !prog_en);

   p_cmd_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clock_dr && capture_dr && sel[2]) |=> (cmd_word == $past(result_in)));

   p_go_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_go |-> prog_en);

   p_tdo_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == 3'b000) |-> !tdo);

   p_cmd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(clock_dr && sel[2] && (capture_dr || shift_dr)) |=> $stable(cmd_word));

   p_key_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!(clock_dr && sel[1] && shift_dr) && !prog_clr) |=> $stable(prog_en));
endmodule

bind isp_dr_bank isp_dr_bank_chk #(.CMD_W(CMD_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sel        (sel),
   .capture_dr (capture_dr),
   .shift_dr   (shift_dr),
   .clock_dr   (clock_dr),
   .tdi        (tdi),
   .prog_clr   (prog_clr),
   .result_in  (result_in),
   .tdo        (tdo),
   .dev_rst    (dev_rst),
   .prog_en    (prog_en),
   .cmd_word   (cmd_word),
   .cmd_go     (cmd_go)
);

// File: tb/isp_dr_bank_test.sv
`timescale 1ns/1ps
module isp_dr_bank_test;
   localparam int CMD_W = 15;
   localparam int MAX_CYCLES = 20000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [2:0]       sel = '0;
   logic             capture_dr = 1'b0;
   logic             shift_dr = 1'b0;
   logic             update_dr = 1'b0;
   logic             clock_dr = 1'b0;
   logic             tdi = 1'b0;
   logic             prog_clr = 1'b0;
   logic [CMD_W-1:0] result_in = '0;
   logic             tdo;
   logic             dev_rst;
   logic             prog_en;
   logic [CMD_W-1:0] cmd_word;
   logic             cmd_go;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   isp_dr_bank uut (
      .clk(clk), .rst_n(rst_n), .sel(sel), .capture_dr(capture_dr),
      .shift_dr(shift_dr), .update_dr(update_dr), .clock_dr(clock_dr),
      .tdi(tdi), .prog_clr(prog_clr), .result_in(result_in), .tdo(tdo),
      .dev_rst(dev_rst), .prog_en(prog_en), .cmd_word(cmd_word), .cmd_go(cmd_go)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle();
      @(negedge clk);
      capture_dr = 0; shift_dr = 0; update_dr = 0; clock_dr = 0; prog_clr = 0;
   endtask

   task automatic shift_in(input logic [2:0] s, input logic [31:0] din,
                           input int n, output logic [31:0] dout);
      dout = '0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         sel = s; shift_dr = 1; clock_dr = 1; tdi = din[i];
         #1 dout[i] = tdo;
      end
      idle();
   endtask

   task automatic pulse_update(input logic [2:0] s, output logic go);
      @(negedge clk);
      sel = s; update_dr = 1;
      #1 go = cmd_go;
      idle();
   endtask

   task automatic t_reset();
      check("R1 dev_rst", 32'(dev_rst), 0);
      check("R1 prog_en", 32'(prog_en), 0);
      check("R1 cmd_word", 32'(cmd_word), 0);
      check("R1 cmd_go", 32'(cmd_go), 0);
      check("R1 tdo", 32'(tdo), 0);
   endtask

   task automatic t_reset_reg();
      logic [31:0] d; logic g;
      shift_in(3'b001, 32'h1, 1, d);
      check("R2 dev_rst set by shift", 32'(dev_rst), 1);
      pulse_update(3'b001, g);
      check("R3 update leaves dev_rst", 32'(dev_rst), 1);
      repeat (3) idle();
      check("R2 dev_rst held", 32'(dev_rst), 1);
      shift_in(3'b001, 32'h0, 1, d);
      check("R2 dev_rst released", 32'(dev_rst), 0);
      check("R2 tdo showed old bit", d, 1);
      pulse_update(3'b001, g);
      check("R3 update leaves dev_rst low", 32'(dev_rst), 0);
   endtask

   task automatic t_unlock();
      logic [31:0] d;
      shift_in(3'b010, 32'hA370, 16, d);
      check("R4 key unlocks", 32'(prog_en), 1);
      shift_in(3'b010, 32'hA371, 16, d);
      check("R5 wrong key locked", 32'(prog_en), 0);
      check("R4 key read back LSB first", d, 32'hA370);
      shift_in(3'b010, 32'h2370, 16, d);
      check("R5 top bit wrong locked", 32'(prog_en), 0);
   endtask

   task automatic t_clear();
      logic [31:0] d;
      shift_in(3'b010, 32'hA370, 16, d);
      check("R4 unlock before clear", 32'(prog_en), 1);
      @(negedge clk);
      sel = 3'b010; prog_clr = 1; shift_dr = 1; clock_dr = 1; tdi = 1;
      idle();
      check("R6 clear locks", 32'(prog_en), 0);
      shift_in(3'b010, 32'h0, 16, d);
      check("R6 register zeroed", d, 0);
   endtask

   task automatic t_cmd();
      logic [31:0] d; logic g;
      shift_in(3'b010, 32'hA370, 16, d);
      result_in = 15'h5A3C;
      @(negedge clk);
      sel = 3'b100; capture_dr = 1; shift_dr = 1; clock_dr = 1; tdi = 1;
      idle();
      check("R7 capture wins over shift", 32'(cmd_word), 32'h5A3C);
      result_in = 15'h1111;
      shift_in(3'b100, 32'h2B4D, 15, d);
      check("R8 result shifted out", d, 32'h5A3C);
      check("R8 command shifted in", 32'(cmd_word), 32'h2B4D);
      pulse_update(3'b100, g);
      check("R9 go while unlocked", 32'(g), 1);
      pulse_update(3'b001, g);
      check("R9 no go for other select", 32'(g), 0);
   endtask

   task automatic t_ignore();
      logic [31:0] d;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         sel = 3'b100; shift_dr = 1; clock_dr = 0; tdi = 0;
      end
      idle();
      check("R11 no shift without clock_dr", 32'(cmd_word), 32'h2B4D);
      shift_in(3'b001, 32'h0, 1, d);
      check("R11 reset shift leaves cmd", 32'(cmd_word), 32'h2B4D);
      check("R11 reset shift leaves key", 32'(prog_en), 1);
      @(negedge clk);
      sel = 3'b010; capture_dr = 1; clock_dr = 1; result_in = 15'h0F0F;
      idle();
      check("R11 capture on key sel leaves cmd", 32'(cmd_word), 32'h2B4D);
   endtask

   task automatic t_tdo();
      @(negedge clk); sel = 3'b000;
      #1 check("R10 tdo idle", 32'(tdo), 0);
      @(negedge clk); sel = 3'b100;
      #1 check("R8 tdo is cmd bit0", 32'(tdo), 1);
      @(negedge clk); sel = 3'b000;
   endtask

   task automatic t_nogo();
      logic g;
      @(negedge clk); prog_clr = 1;
      idle();
      pulse_update(3'b100, g);
      check("R9 no go while locked", 32'(g), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 tdo in reset", 32'(tdo), 0);
      check("R1 dev_rst in reset", 32'(dev_rst), 0);
      rst_n = 1;
      t_reset();
      t_reset_reg();
      t_unlock();
      t_clear();
      t_cmd();
      t_ignore();
      t_tdo();
      t_nogo();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (MAX_CYCLES) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule